// File: doc/BRIEF.md
# Hexadecimal floating-point adder

This block adds or subtracts two floating-point operands whose exponent is a power of sixteen. Each operand is one 64-bit word holding a sign, a 7-bit characteristic biased by 64, and a 56-bit fraction. The value of a word is (-1)^sign × 16^(characteristic − 64) × fraction, with the fraction read as a binary fraction in [0, 1). Because the base is sixteen, every shift the block makes, whether to align or to normalize, moves the fraction by whole 4-bit hex digits.

The first pipeline stage orders the two operands so that the larger one leads. It shifts the smaller one right by the characteristic difference, keeping one guard digit. For an effective subtraction it inverts the shifted operand through XOR gates, then adds. The second stage either absorbs a carry-out or removes leading zero digits, adjusts the characteristic to match, truncates back to 14 digits and registers the result. A short-format select runs the same hardware on 6-digit fractions by forcing the lower fraction bits to zero. A new operation can enter on every clock, and its result leaves two clocks later.

Top module: `hfa_adder`

## Requirements
- R1: Word layout: bit 63 is the sign, bits 62:56 the characteristic, bits 55:0 the fraction, bit 55 being the fraction's most significant bit (weight 1/2); this layout holds for both operands and the result.
- R2: An operation is taken at a rising clock edge when `a_vld` and `b_vld` are both 1, one per cycle with no stall; `res_vld` is 1 exactly two edges later, and in a cycle with no result `res_vld`, `res_word`, `exp_ovf` and `exp_unf` are all 0.
- R3: When `sub_op` is 1 the sign of operand B is inverted before the operation; the result sign is that of the operand with the larger (characteristic, fraction) pair, with A winning a tie, and it is flipped if the magnitude difference comes out negative.
- R4: The smaller operand is shifted right by the characteristic difference in hex digits into a 15-digit field (14 fraction digits plus one guard digit); digits shifted past the guard digit are lost, and a difference of 15 or more makes it contribute zero.
- R5: A carry out of the fraction sum shifts the sum right by one hex digit and adds 1 to the characteristic.
- R6: A nonzero result is normalized so that fraction bits 55:52 are nonzero, the characteristic dropping by 1 for every leading zero digit removed; the guard digit is then discarded (truncation, no rounding).
- R7: A zero sum produces an all-zero result word (positive sign, characteristic 0) with both flags 0.
- R8: When `short_fmt` is 1, fraction bits 31:0 of both operands are treated as zero and bits 31:0 of the result fraction are 0.
- R9: If the adjusted characteristic exceeds 127, `exp_ovf` is 1 and the low 7 bits of the adjusted value are reported as the characteristic.
- R10: If the adjusted characteristic falls below 0, `exp_unf` is 1 and the low 7 bits of the two's-complement value are reported as the characteristic.
- R11: While `rst_n` is 0 every output is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_vld | input | 1 | Operand A present |
| b_vld | input | 1 | Operand B present |
| op_a | input | 64 | Operand A word |
| op_b | input | 64 | Operand B word |
| sub_op | input | 1 | 1 = subtract B from A, 0 = add |
| short_fmt | input | 1 | 1 = short format (6 fraction digits), 0 = long format |
| res_vld | output | 1 | Result word valid |
| res_word | output | 64 | Result word |
| exp_ovf | output | 1 | Characteristic overflow |
| exp_unf | output | 1 | Characteristic underflow |

## Verification
Equal characteristics with same-sign operands separate the plain sum from the carry-out path. Opposite signs with equal characteristics, or with characteristics one apart, exercise cancellation, the guard digit and the sign flip. Characteristic gaps of 1, 5, 14, 15 and 40 probe the boundary at which the smaller operand flushes to zero. Short-format pairs carry nonzero low fraction bits, so that a missing mask shows up in the result. Operands at the top and bottom of the characteristic range drive the overflow and underflow flags. Long random streams with gaps in the valid inputs check back-to-back issue, the two-cycle latency and the quiet outputs between results.

// File: rtl/hfa_pkg.sv
package hfa_pkg;
    localparam int CHAR_W       = 7;
    localparam int FRAC_W       = 56;
    localparam int SHORT_W      = 24;
    localparam int GUARD_DIGITS = 1;
    localparam int DIGIT_W      = 4;

    localparam int WORD_W      = 1 + CHAR_W + FRAC_W;
    localparam int WIDE_W      = FRAC_W + DIGIT_W * GUARD_DIGITS;
    localparam int SUM_W       = WIDE_W + 1;
    localparam int WIDE_DIGITS = WIDE_W / DIGIT_W;
    localparam int LZ_W        = $clog2(WIDE_DIGITS + 1);
    localparam int EXP_W       = CHAR_W + 2;

    // Stage 1: aligned and added magnitude waiting for normalization
    typedef struct packed {
        logic              vld;
        logic              short_fmt;
        logic              sign;
        logic [CHAR_W-1:0] chr;
        logic [SUM_W-1:0]  mag;
    } sum_t;

    // Stage 2: finished result
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] word;
        logic              ovf;
        logic              unf;
    } res_t;

    typedef struct packed {
        sum_t s1;
        res_t s2;
    } pipe_t;
endpackage

// File: rtl/hfa_align.sv
module hfa_align
    import hfa_pkg::*;
(
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              sub_op,
    input  logic              short_fmt,
    output logic              sign,
    output logic [CHAR_W-1:0] chr,
    output logic [SUM_W-1:0]  mag
);
    localparam logic [FRAC_W-1:0] SHORT_KEEP =
        {{SHORT_W{1'b1}}, {(FRAC_W - SHORT_W){1'b0}}};

    logic [FRAC_W-1:0] keep_mask, fa, fb, big_f, small_f;
    logic [CHAR_W-1:0] ca, cb, big_c, small_c, gap;
    logic              sa, sb, big_s, small_s, a_leads, eff_sub, neg;
    logic [WIDE_W-1:0] big_w, small_w, small_al;
    logic [SUM_W-1:0]  raw;

    always_comb begin
        keep_mask = short_fmt ? SHORT_KEEP : '1;
        fa = op_a[FRAC_W-1:0] & keep_mask;
        fb = op_b[FRAC_W-1:0] & keep_mask;
        ca = op_a[FRAC_W +: CHAR_W];
        cb = op_b[FRAC_W +: CHAR_W];
        sa = op_a[WORD_W-1];
        sb = op_b[WORD_W-1] ^ sub_op;

        // compare and swap: larger (characteristic, fraction) leads
        a_leads = (ca > cb) || ((ca == cb) && (fa >= fb));
        big_f   = a_leads ? fa : fb;
        small_f = a_leads ? fb : fa;
        big_c   = a_leads ? ca : cb;
        small_c = a_leads ? cb : ca;
        big_s   = a_leads ? sa : sb;
        small_s = a_leads ? sb : sa;

        // hex-digit alignment with guard digit
        gap     = big_c - small_c;
        big_w   = {big_f, {(DIGIT_W * GUARD_DIGITS){1'b0}}};
        small_w = {small_f, {(DIGIT_W * GUARD_DIGITS){1'b0}}};
        if (gap >= CHAR_W'(WIDE_DIGITS))
            small_al = '0;
        else
            small_al = small_w >> (DIGIT_W * int'(gap));

        // conditional inversion and add
        eff_sub = big_s ^ small_s;
        raw = {1'b0, big_w} + ({1'b0, small_al} ^ {SUM_W{eff_sub}})
              + SUM_W'(eff_sub);
        neg  = eff_sub & raw[SUM_W-1];
        mag  = neg ? (~raw + SUM_W'(1)) : raw;
        sign = big_s ^ neg;
        chr  = big_c;
    end
endmodule

// File: rtl/hfa_lzd.sv
module hfa_lzd
    import hfa_pkg::*;
#(
    parameter int N = WIDE_DIGITS
) (
    input  logic [N*DIGIT_W-1:0]  val,
    output logic [LZ_W-1:0]       count,
    output logic                  all_zero
);
    logic [N-1:0] nz;

    for (genvar g = 0; g < N; g++) begin : g_dig
        assign nz[g] = |val[g*DIGIT_W +: DIGIT_W];
    end

    always_comb begin
        count = '0;
        for (int i = 0; i < N; i++) begin
            if (nz[i]) count = LZ_W'(N - 1 - i);
        end
        all_zero = ~|nz;
    end
endmodule

// File: rtl/hfa_norm.sv
module hfa_norm
    import hfa_pkg::*;
(
    input  logic [SUM_W-1:0]  mag,
    input  logic [CHAR_W-1:0] chr,
    input  logic              sign,
    input  logic              short_fmt,
    output logic [WORD_W-1:0] word,
    output logic              ovf,
    output logic              unf
);
    localparam logic [FRAC_W-1:0] SHORT_KEEP =
        {{SHORT_W{1'b1}}, {(FRAC_W - SHORT_W){1'b0}}};

    logic [LZ_W-1:0]   lz;
    logic              all_zero, carry, zero;
    logic [WIDE_W-1:0] wide;
    logic [FRAC_W-1:0] frac;
    logic [EXP_W-1:0]  exp_u;

    hfa_lzd #(.N(WIDE_DIGITS)) u_lzd (
        .val      (mag[WIDE_W-1:0]),
        .count    (lz),
        .all_zero (all_zero)
    );

    always_comb begin
        carry = mag[SUM_W-1];
        zero  = !carry && all_zero;
        if (carry) begin
            wide  = WIDE_W'(mag[SUM_W-1:DIGIT_W]);
            exp_u = EXP_W'(chr) + EXP_W'(1);
        end else begin
            wide  = mag[WIDE_W-1:0] << (DIGIT_W * int'(lz));
            exp_u = EXP_W'(chr) - EXP_W'(lz);
        end
        frac = FRAC_W'(wide >> (DIGIT_W * GUARD_DIGITS));
        if (short_fmt) frac = frac & SHORT_KEEP;

        if (zero) begin
            word = '0;
            ovf  = 1'b0;
            unf  = 1'b0;
        end else begin
            word = {sign, exp_u[CHAR_W-1:0], frac};
            unf  = exp_u[EXP_W-1];
            ovf  = !exp_u[EXP_W-1] && exp_u[CHAR_W];
        end
    end
endmodule

// File: rtl/hfa_adder.sv
module hfa_adder
    import hfa_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_vld,
    input  logic              b_vld,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic              sub_op,
    input  logic              short_fmt,
    output logic              res_vld,
    output logic [WORD_W-1:0] res_word,
    output logic              exp_ovf,
    output logic              exp_unf
);
    pipe_t pipe_d, pipe_q;

    logic              al_sign;
    logic [CHAR_W-1:0] al_chr;
    logic [SUM_W-1:0]  al_mag;
    logic [WORD_W-1:0] nm_word;
    logic              nm_ovf, nm_unf;

    hfa_align u_align (
        .op_a      (op_a),
        .op_b      (op_b),
        .sub_op    (sub_op),
        .short_fmt (short_fmt),
        .sign      (al_sign),
        .chr       (al_chr),
        .mag       (al_mag)
    );

    hfa_norm u_norm (
        .mag       (pipe_q.s1.mag),
        .chr       (pipe_q.s1.chr),
        .sign      (pipe_q.s1.sign),
        .short_fmt (pipe_q.s1.short_fmt),
        .word      (nm_word),
        .ovf       (nm_ovf),
        .unf       (nm_unf)
    );

    always_comb begin
        pipe_d = pipe_q;

        pipe_d.s1.vld = a_vld && b_vld;
        if (a_vld && b_vld) begin
            pipe_d.s1.short_fmt = short_fmt;
            pipe_d.s1.sign      = al_sign;
            pipe_d.s1.chr       = al_chr;
            pipe_d.s1.mag       = al_mag;
        end

        pipe_d.s2.vld = pipe_q.s1.vld;
        if (pipe_q.s1.vld) begin
            pipe_d.s2.word = nm_word;
            pipe_d.s2.ovf  = nm_ovf;
            pipe_d.s2.unf  = nm_unf;
        end else begin
            pipe_d.s2.word = '0;
            pipe_d.s2.ovf  = 1'b0;
            pipe_d.s2.unf  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign res_vld  = pipe_q.s2.vld;
    assign res_word = pipe_q.s2.word;
    assign exp_ovf  = pipe_q.s2.ovf;
    assign exp_unf  = pipe_q.s2.unf;
endmodule

// File: rtl/hfa_adder_chk.sv
module hfa_adder_chk
    import hfa_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              a_vld,
    input logic              b_vld,
    input logic              short_fmt,
    input logic              res_vld,
    input logic [WORD_W-1:0] res_word,
    input logic              exp_ovf,
    input logic              exp_unf
);
    logic fire;
    assign fire = a_vld && b_vld;

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ##2 res_vld);

    p_no_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !fire |-> ##2 !res_vld);

    p_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !res_vld |-> (res_word == '0) && !exp_ovf && !exp_unf);

    p_lead_digit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && (res_word[FRAC_W-1:0] != '0))
            |-> (res_word[FRAC_W-1 -: DIGIT_W] != '0));

    p_true_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (res_vld && (res_word[FRAC_W-1:0] == '0))
            |-> (res_word[WORD_W-1:FRAC_W] == '0) && !exp_ovf && !exp_unf);

    p_short_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && short_fmt) |-> ##2 (res_word[FRAC_W-SHORT_W-1:0] == '0));

    p_flags_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exp_ovf, exp_unf}));

    always_comb begin
        if (!rst_n) begin
            a_reset_r11: assert (!res_vld && !exp_ovf && !exp_unf);
        end
    end
endmodule

bind hfa_adder hfa_adder_chk u_chk (.*);

// File: tb/hfa_adder_tb.sv
module hfa_adder_tb;
    localparam int WD_LIMIT = 20000;

    typedef struct {
        logic        vld;
        logic [63:0] w;
        logic        ovf;
        logic        unf;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        a_vld = 1'b0, b_vld = 1'b0, sub_op = 1'b0, short_fmt = 1'b0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        res_vld, exp_ovf, exp_unf;
    logic [63:0] res_word;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    string cur_tag = "R2";
    exp_t  exp_q[$];

    always #10 clk = ~clk;

    hfa_adder u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .a_vld     (a_vld),
        .b_vld     (b_vld),
        .op_a      (op_a),
        .op_b      (op_b),
        .sub_op    (sub_op),
        .short_fmt (short_fmt),
        .res_vld   (res_vld),
        .res_word  (res_word),
        .exp_ovf   (exp_ovf),
        .exp_unf   (exp_unf)
    );

    function automatic logic [63:0] mk(input logic s, input logic [6:0] c,
                                       input logic [55:0] f);
        return {s, c, f};
    endfunction

    // Behavioural model of the requirements
    function automatic exp_t model(input logic av, input logic bv,
                                   input logic [63:0] a, input logic [63:0] b,
                                   input logic sub, input logic shrt);
        exp_t        r;
        logic [55:0] fa, fb, bf, sf, fr;
        int          ca, cb, bc, sc, d, e;
        logic        sa, sb, bs, ss, s;
        logic [63:0] bm, sm, m;
        r.vld = av && bv; r.w = '0; r.ovf = 0; r.unf = 0; r.tag = "";
        if (!r.vld) return r;
        fa = a[55:0]; fb = b[55:0];
        if (shrt) begin fa[31:0] = '0; fb[31:0] = '0; end
        ca = int'(a[62:56]); cb = int'(b[62:56]);
        sa = a[63]; sb = b[63] ^ sub;
        if (ca > cb || (ca == cb && fa >= fb)) begin
            bf = fa; bc = ca; bs = sa; sf = fb; sc = cb; ss = sb;
        end else begin
            bf = fb; bc = cb; bs = sb; sf = fa; sc = ca; ss = sa;
        end
        d  = bc - sc;
        bm = {4'h0, bf, 4'h0};
        sm = (d >= 15) ? 64'h0 : ({4'h0, sf, 4'h0} >> (4 * d));
        s  = bs;
        if (bs == ss) m = bm + sm;
        else if (sm > bm) begin m = sm - bm; s = ~s; end
        else m = bm - sm;
        if (m == 0) return r;
        e = bc;
        if (m[63:60] != 0) begin m = m >> 4; e = e + 1; end
        while (m[59:56] == 0) begin m = m << 4; e = e - 1; end
        fr = m[59:4];
        if (shrt) fr[31:0] = '0;
        r.ovf = (e > 127);
        r.unf = (e < 0);
        r.w   = {s, e[6:0], fr};
        return r;
    endfunction

    always @(posedge clk) begin
        exp_t x;
        if (rst_n) begin
            x = model(a_vld, b_vld, op_a, op_b, sub_op, short_fmt);
            x.tag = cur_tag;
            exp_q.push_back(x);
        end
    end

    always @(negedge clk) begin
        exp_t x;
        if (rst_n && exp_q.size() == 2) begin
            x = exp_q.pop_front();
            checks++;
            if (res_vld !== x.vld || res_word !== x.w ||
                exp_ovf !== x.ovf || exp_unf !== x.unf) begin
                errors++;
                $display("FAIL %s: got vld=%b word=%h ovf=%b unf=%b, expected vld=%b word=%h ovf=%b unf=%b",
                         x.tag, res_vld, res_word, exp_ovf, exp_unf,
                         x.vld, x.w, x.ovf, x.unf);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc >= WD_LIMIT) begin
            errors++;
            $display("FAIL R2 watchdog: ran %0d cycles, expected fewer than %0d", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic issue(input logic av, input logic bv, input logic [63:0] a,
                         input logic [63:0] b, input logic sub, input logic sh,
                         input string tag);
        @(negedge clk);
        a_vld = av; b_vld = bv; op_a = a; op_b = b;
        sub_op = sub; short_fmt = sh; cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) issue(0, 0, '0, '0, 0, 0, "R2");
    endtask

    function automatic logic [55:0] rnd_frac();
        logic [55:0] f;
        f = 56'({$urandom, $urandom});
        if (f[55:52] == 4'h0) f[55:52] = 4'h1;
        return f;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (res_vld !== 1'b0 || res_word !== 64'h0 || exp_ovf !== 1'b0 || exp_unf !== 1'b0) begin
            errors++;
            $display("FAIL R11: got vld=%b word=%h ovf=%b unf=%b, expected all zero",
                     res_vld, res_word, exp_ovf, exp_unf);
        end
        rst_n = 1'b1;

        // R1: field layout with a plain sum
        issue(1, 1, mk(0, 7'h41, 56'h10000000000000), mk(0, 7'h41, 56'h20000000000000), 0, 0, "R1");
        issue(1, 1, mk(0, 7'h45, 56'hABCDEF01234567), mk(0, 7'h44, 56'h12345678ABCDEF), 0, 0, "R1");
        // R3: subtraction signs
        issue(1, 1, mk(0, 7'h41, 56'h10000000000000), mk(0, 7'h41, 56'h30000000000000), 1, 0, "R3");
        issue(1, 1, mk(1, 7'h42, 56'h50000000000000), mk(0, 7'h41, 56'h70000000000000), 0, 0, "R3");
        issue(1, 1, mk(1, 7'h40, 56'h20000000000000), mk(1, 7'h40, 56'h90000000000000), 1, 0, "R3");
        // R5: carry out
        issue(1, 1, mk(0, 7'h41, 56'h80000000000000), mk(0, 7'h41, 56'h80000000000000), 0, 0, "R5");
        issue(1, 1, mk(1, 7'h50, 56'hFFFFFFFFFFFFFF), mk(1, 7'h4F, 56'hF0000000000000), 0, 0, "R5");
        // R4: alignment distances
        issue(1, 1, mk(0, 7'h42, 56'h12345678ABCDEF), mk(0, 7'h41, 56'hFEDCBA98765432), 0, 0, "R4");
        issue(1, 1, mk(0, 7'h46, 56'h12345678ABCDEF), mk(0, 7'h41, 56'hFEDCBA98765432), 0, 0, "R4");
        issue(1, 1, mk(0, 7'h4F, 56'h12345678ABCDEF), mk(0, 7'h41, 56'hFEDCBA98765432), 1, 0, "R4");
        issue(1, 1, mk(0, 7'h50, 56'h12345678ABCDEF), mk(0, 7'h41, 56'hFEDCBA98765432), 1, 0, "R4");
        issue(1, 1, mk(0, 7'h30, 56'hFEDCBA98765432), mk(0, 7'h58, 56'h12345678ABCDEF), 0, 0, "R4");
        // R6: cancellation and guard digit
        issue(1, 1, mk(0, 7'h41, 56'h10000000000001), mk(0, 7'h41, 56'h10000000000000), 1, 0, "R6");
        issue(1, 1, mk(0, 7'h42, 56'h10000000000000), mk(0, 7'h41, 56'hFFFFFFFFFFFFFF), 1, 0, "R6");
        issue(1, 1, mk(0, 7'h42, 56'h10000000000000), mk(1, 7'h41, 56'h00000000000001), 0, 0, "R6");
        // R7: exact cancellation
        issue(1, 1, mk(0, 7'h41, 56'h12345678ABCDEF), mk(0, 7'h41, 56'h12345678ABCDEF), 1, 0, "R7");
        issue(1, 1, mk(1, 7'h60, 56'h87654321000000), mk(0, 7'h60, 56'h87654321000000), 0, 0, "R7");
        // R8: short format with low bits that must be ignored
        issue(1, 1, mk(0, 7'h41, 56'h123456FFFFFFFF), mk(0, 7'h41, 56'h654321FFFFFFFF), 0, 1, "R8");
        issue(1, 1, mk(0, 7'h41, 56'h123456FFFFFFFF), mk(0, 7'h41, 56'h12345600000000), 1, 1, "R8");
        issue(1, 1, mk(0, 7'h43, 56'hABCDEF00000000), mk(1, 7'h41, 56'h987654ABCDEF12), 0, 1, "R8");
        // R9: overflow
        issue(1, 1, mk(0, 7'h7F, 56'h80000000000000), mk(0, 7'h7F, 56'h80000000000000), 0, 0, "R9");
        // R10: underflow
        issue(1, 1, mk(0, 7'h00, 56'h11000000000000), mk(0, 7'h00, 56'h10000000000000), 1, 0, "R10");
        issue(1, 1, mk(1, 7'h02, 56'h10000000000001), mk(1, 7'h02, 56'h10000000000000), 1, 0, "R10");
        // R2: one operand present only, then back-to-back issue
        issue(1, 0, mk(0, 7'h41, 56'h10000000000000), mk(0, 7'h41, 56'h10000000000000), 0, 0, "R2");
        issue(0, 1, mk(0, 7'h41, 56'h10000000000000), mk(0, 7'h41, 56'h10000000000000), 0, 0, "R2");
        idle(2);

        for (int i = 0; i < 600; i++) begin
            logic [6:0]  ca, cb;
            logic        go;
            ca = 7'($urandom_range(2, 125));
            cb = ca + 7'($urandom_range(0, 4)) - 7'(2);
            if (i % 7 == 0) cb = 7'($urandom_range(0, 127));
            go = ($urandom_range(0, 3) != 0);
            issue(go, go | 1'($urandom_range(0, 1)),
                  mk(1'($urandom_range(0, 1)), ca, rnd_frac()),
                  mk(1'($urandom_range(0, 1)), cb, rnd_frac()),
                  1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                  (i % 2 == 0) ? "R3" : "R6");
        end
        idle(4);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule